// File: doc/BRIEF.md
# SMBus Clock-Low Timeout and Alert Unit

This block sits beside an I2C/SMBus slave core. It watches the synchronized SCL and SDA levels while the bus is busy and counts how many clock cycles SCL stays low. When that count reaches a limit that software programs, the block tells the slave core to let go of both lines and abandon the transfer. It also sets a timeout status bit that stays set until software clears it.

The same block handles the slave's alert signalling. When software raises an alert request, the block pulls the shared SMBALERT line low through an open-drain enable. While the alert is raised, it also enables a match on the Alert Response Address, so a host that polls that address finds this slave. The byte protocol and packet error checking stay in the slave core.

Top module: `smbus_guard`

## Requirements
- R1: After reset, `release_o`, `tmo_flag_o`, `alert_oe_o`, `ara_en_o` and `ara_hit_o` are all 0.
- R2: With `bus_busy_i` high and `scl_i` low, with a nonzero limit L, `release_o` and `tmo_flag_o` stay 0 for L rising clock edges. They become 1 at the (L+1)th edge.
- R3: Any clock edge that sees `scl_i` high restarts the low-time count from zero. A later low phase therefore needs the full L+1 edges again.
- R4: While `bus_busy_i` is low the count stays at zero, so SCL held low never causes a timeout.
- R5: Once set, `release_o` stays 1 until a STOP is seen (`sda_i` rising while `scl_i` is high, on two consecutive edges) or until `bus_busy_i` goes low. It clears at the edge that sees that event.
- R6: `tmo_flag_o` is sticky. A STOP or an idle bus does not clear it. It clears at the edge after `tmo_clr_i` is high, unless a new timeout happens in that same cycle, in which case the set wins.
- R7: A limit of 0 disables the timeout: `release_o` and `tmo_flag_o` never rise.
- R8: `alert_oe_o` (1 = drive SMBALERT low, 0 = released) and `ara_en_o` both follow `alert_req_i` with one clock of delay.
- R9: `ara_hit_o` is 1 in the same cycle when `ara_en_o` is 1, `addr_valid_i` is 1 and `addr_i` equals the 7-bit value 0001100 (0x0C).
- R10: `ara_hit_o` is 0 for any other address, and for any address while `ara_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| bus_busy_i | input | 1 | Bus is inside a transfer (START seen, no STOP yet) |
| tmo_limit_i | input | LIM_W | Timeout limit in clock cycles; 0 disables |
| tmo_clr_i | input | 1 | Software clear of the timeout status bit |
| alert_req_i | input | 1 | Software alert control bit |
| addr_i | input | 7 | Received slave address from the core |
| addr_valid_i | input | 1 | `addr_i` is valid this cycle |
| release_o | output | 1 | Request to the core to free SCL/SDA and drop the transfer |
| tmo_flag_o | output | 1 | Sticky timeout status bit |
| alert_oe_o | output | 1 | Open-drain enable for SMBALERT (1 pulls low) |
| ara_en_o | output | 1 | Alert Response Address match enabled |
| ara_hit_o | output | 1 | Received address is the Alert Response Address while enabled |

## Verification
On every cycle the assertions check several local rules. The alert outputs follow the request bit one cycle later. An address hit only occurs with the match enabled and the correct address. The status bit only falls after a clear request and never rises when the limit is zero. The release request only rises while SCL is low during a busy bus. The exact edge count at which a timeout fires can only be shown by the bench scenarios. The same holds for the restart of the count on an SCL high phase, the immunity while the bus is idle, and the release being held until STOP.

// File: rtl/smbg_pkg.sv
package smbg_pkg;

    localparam int unsigned ADDR_W = 7;
    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100;

    // Bus events derived from the synchronized line levels
    typedef struct packed {
        logic scl_low;
        logic scl_rise;
        logic stop;
    } bus_ev_t;

    function automatic logic is_ara(input logic [ADDR_W-1:0] a);
        return a == ARA_ADDR;
    endfunction

endpackage

// File: rtl/smbg_busmon.sv
module smbg_busmon
    import smbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.scl_low  = ~scl_i;
        ev_o.scl_rise = scl_i & ~scl_q;
        ev_o.stop     = scl_i & scl_q & sda_i & ~sda_q;
    end
endmodule

// File: rtl/smbg_timer.sv
module smbg_timer
    import smbg_pkg::*;
#(
    parameter int unsigned LIM_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev_i,
    input  logic             busy_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             expire_o
);
    logic [LIM_W-1:0] cnt_q;
    logic             restart;

    assign restart = ~busy_i | ~ev_i.scl_low | ev_i.scl_rise | ev_i.stop;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire_o = busy_i & ev_i.scl_low & (limit_i != '0) & (cnt_q >= limit_i);
endmodule

// File: rtl/smbg_alert.sv
module smbg_alert
    import smbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_valid_i,
    output logic              oe_o,
    output logic              ara_en_o,
    output logic              hit_o
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_i;
    end

    assign oe_o     = req_q;
    assign ara_en_o = req_q;
    assign hit_o    = req_q & addr_valid_i & is_ara(addr_i);
endmodule

// File: rtl/smbus_guard.sv
module smbus_guard
    import smbg_pkg::*;
#(
    parameter int unsigned LIM_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              bus_busy_i,
    input  logic [LIM_W-1:0]  tmo_limit_i,
    input  logic              tmo_clr_i,
    input  logic              alert_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_valid_i,
    output logic              release_o,
    output logic              tmo_flag_o,
    output logic              alert_oe_o,
    output logic              ara_en_o,
    output logic              ara_hit_o
);
    bus_ev_t ev;
    logic    expire;
    logic    release_q;
    logic    flag_q;

    smbg_busmon u_busmon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    smbg_timer #(.LIM_W(LIM_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .busy_i   (bus_busy_i),
        .limit_i  (tmo_limit_i),
        .expire_o (expire)
    );

    smbg_alert u_alert (
        .clk          (clk),
        .rst          (rst),
        .req_i        (alert_req_i),
        .addr_i       (addr_i),
        .addr_valid_i (addr_valid_i),
        .oe_o         (alert_oe_o),
        .ara_en_o     (ara_en_o),
        .hit_o        (ara_hit_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            release_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (expire)                      release_q <= 1'b1;
            else if (ev.stop || !bus_busy_i) release_q <= 1'b0;
            if (expire)                      flag_q <= 1'b1;
            else if (tmo_clr_i)              flag_q <= 1'b0;
        end
    end

    assign release_o  = release_q;
    assign tmo_flag_o = flag_q;
endmodule

module smbg_chk
    import smbg_pkg::*;
#(
    parameter int unsigned LIM_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              bus_busy_i,
    input logic [LIM_W-1:0]  tmo_limit_i,
    input logic              tmo_clr_i,
    input logic              alert_req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              addr_valid_i,
    input logic              release_o,
    input logic              tmo_flag_o,
    input logic              alert_oe_o,
    input logic              ara_en_o,
    input logic              ara_hit_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !release_o && !tmo_flag_o && !alert_oe_o && !ara_en_o);
    // R2
    release_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> $past(!scl_i && bus_busy_i));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);
    // R7
    flag_needs_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_flag_o) |-> $past(tmo_limit_i) != '0);
    // R8
    alert_follow_chk: assert property (@(posedge clk) disable iff (rst)
        alert_req_i |=> (alert_oe_o && ara_en_o));
    // R8
    alert_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !alert_req_i |=> (!alert_oe_o && !ara_en_o));
    // R9
    hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
        ara_hit_o |-> (ara_en_o && addr_valid_i && addr_i == ARA_ADDR));
    // R10
    hit_off_chk: assert property (@(posedge clk) disable iff (rst)
        !ara_en_o |-> !ara_hit_o);
endmodule

bind smbus_guard smbg_chk #(.LIM_W(LIM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .bus_busy_i   (bus_busy_i),
    .tmo_limit_i  (tmo_limit_i),
    .tmo_clr_i    (tmo_clr_i),
    .alert_req_i  (alert_req_i),
    .addr_i       (addr_i),
    .addr_valid_i (addr_valid_i),
    .release_o    (release_o),
    .tmo_flag_o   (tmo_flag_o),
    .alert_oe_o   (alert_oe_o),
    .ara_en_o     (ara_en_o),
    .ara_hit_o    (ara_hit_o)
);

// File: tb/test_smbus_guard.sv
module test_smbus_guard;
    localparam int unsigned LIM_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             scl_i, sda_i, bus_busy_i, tmo_clr_i, alert_req_i, addr_valid_i;
    logic [LIM_W-1:0] tmo_limit_i;
    logic [6:0]       addr_i;
    logic             release_o, tmo_flag_o, alert_oe_o, ara_en_o, ara_hit_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smbus_guard #(.LIM_W(LIM_W)) i_smbus_guard (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .bus_busy_i(bus_busy_i),
        .tmo_limit_i(tmo_limit_i), .tmo_clr_i(tmo_clr_i), .alert_req_i(alert_req_i),
        .addr_i(addr_i), .addr_valid_i(addr_valid_i), .release_o(release_o),
        .tmo_flag_o(tmo_flag_o), .alert_oe_o(alert_oe_o), .ara_en_o(ara_en_o),
        .ara_hit_o(ara_hit_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        tmo_clr_i = 1'b1; step(1); tmo_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; scl_i = 1'b1; sda_i = 1'b1; bus_busy_i = 1'b0; tmo_clr_i = 1'b0;
        alert_req_i = 1'b0; addr_valid_i = 1'b0; addr_i = '0; tmo_limit_i = 16'd5;
        step(3); rst = 1'b0; step(1);
        check("R1 release", release_o, 1'b0);
        check("R1 flag", tmo_flag_o, 1'b0);
        check("R1 alert_oe", alert_oe_o, 1'b0);
        check("R1 ara_en", ara_en_o, 1'b0);
        check("R1 hit", ara_hit_o, 1'b0);
    endtask

    task automatic t_timeout();
        sda_i = 1'b0; bus_busy_i = 1'b1; step(1);
        scl_i = 1'b0; step(5);
        check("R2 release before limit", release_o, 1'b0);
        check("R2 flag before limit", tmo_flag_o, 1'b0);
        step(1);
        check("R2 release at limit", release_o, 1'b1);
        check("R2 flag at limit", tmo_flag_o, 1'b1);
        scl_i = 1'b1; step(1);
        check("R5 release held", release_o, 1'b1);
        sda_i = 1'b1; step(1);
        check("R5 release cleared by STOP", release_o, 1'b0);
        check("R6 flag survives STOP", tmo_flag_o, 1'b1);
        bus_busy_i = 1'b0; step(2);
        check("R6 flag survives idle", tmo_flag_o, 1'b1);
        clear_flag(); step(1);
        check("R6 flag cleared", tmo_flag_o, 1'b0);
    endtask

    task automatic t_restart();
        sda_i = 1'b0; bus_busy_i = 1'b1; step(1);
        scl_i = 1'b0; step(4);
        scl_i = 1'b1; step(1);
        scl_i = 1'b0; step(5);
        check("R3 no timeout after restart", release_o, 1'b0);
        step(1);
        check("R3 timeout after full window", release_o, 1'b1);
        bus_busy_i = 1'b0; step(1);
        check("R5 release cleared by idle bus", release_o, 1'b0);
        scl_i = 1'b1; sda_i = 1'b1; clear_flag(); step(1);
    endtask

    task automatic t_idle();
        bus_busy_i = 1'b0; scl_i = 1'b0; step(20);
        check("R4 idle release", release_o, 1'b0);
        check("R4 idle flag", tmo_flag_o, 1'b0);
        scl_i = 1'b1; step(1);
    endtask

    task automatic t_limit_zero();
        tmo_limit_i = '0; sda_i = 1'b0; bus_busy_i = 1'b1; scl_i = 1'b0; step(40);
        check("R7 limit zero release", release_o, 1'b0);
        check("R7 limit zero flag", tmo_flag_o, 1'b0);
        bus_busy_i = 1'b0; scl_i = 1'b1; sda_i = 1'b1; tmo_limit_i = 16'd5; step(1);
    endtask

    task automatic t_alert();
        alert_req_i = 1'b1; step(1);
        check("R8 alert_oe on", alert_oe_o, 1'b1);
        check("R8 ara_en on", ara_en_o, 1'b1);
        addr_i = 7'h0C; addr_valid_i = 1'b1; #1;
        check("R9 ARA hit", ara_hit_o, 1'b1);
        addr_i = 7'h0D; #1;
        check("R10 other address", ara_hit_o, 1'b0);
        addr_i = 7'h0C; addr_valid_i = 1'b0; #1;
        check("R9 needs valid", ara_hit_o, 1'b0);
        step(1);
        alert_req_i = 1'b0; step(1);
        check("R8 alert_oe off", alert_oe_o, 1'b0);
        check("R8 ara_en off", ara_en_o, 1'b0);
        addr_valid_i = 1'b1; #1;
        check("R10 ARA while disabled", ara_hit_o, 1'b0);
        addr_valid_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_timeout();
        t_restart();
        t_idle();
        t_limit_zero();
        t_alert();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule